// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block owns the operating state of a serial data engine. Software picks one of three states (idle-with-reset, running, or frozen) by writing a 2-bit code into a state register. A fourth code serves as a clear command. After each accepted request the block drops a settle flag for a fixed number of cycles and then raises it again. Software polls this flag before and after every state request. Three decoded control lines go to the data path: run, freeze and reset-hold. Exactly one of them is high at any time.

Getting from the frozen state back to idle is deliberately harder than any other move. It needs two clear commands in a row. A single clear only arms the exit, and any other code written next disarms it. A software-reset register forces the block to idle at any time and wipes two configuration registers that sit next to the state register. The data engine itself, meaning the shifter and the buffers, lies outside this block.

Top module: `sereng_state_ctrl`

## Requirements
- R1: After rst_ni is released the state is idle (code 0), the settle flag is 1, hold_rst_o is 1, and the mode and operation registers read 0.
- R2: The state codes are 0 idle, 1 running and 3 frozen. An accepted write of one of them to address 0 (bits [1:0]) sets the state in the next cycle. hold_rst_o, run_o and pause_o decode codes 0, 1 and 3 respectively, and exactly one of them is high.
- R3: A read of address 0 returns the state in bits [1:0], the settle flag in bit 2 and zero above. After an accepted state change the settle flag reads 0 for SETTLE_CYC cycles and then reads 1.
- R4: A write to address 0 while the settle flag is 0 is ignored and leaves state and outputs unchanged.
- R5: In the frozen state a first clear write (code 2) leaves the state frozen and the settle flag at 1. A clear write directly following it moves the state to idle and drops the settle flag.
- R6: In the frozen state with one clear pending, a write of any other code cancels the pending clear and the state stays frozen. A later single clear then again does not leave the frozen state.
- R7: A clear write while idle or running changes neither the state nor the settle flag.
- R8: A write to address 3 with bit 0 set forces the state to idle, cancels any pending clear, zeroes the mode and operation registers and starts a settle period. This happens even while the settle flag is 0. With bit 0 clear the write has no effect, and address 3 reads 0.
- R9: Addresses 1 (mode) and 2 (operation) store the low CFG_W bits written and read them back zero-extended. These writes are accepted whatever the settle flag is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 state, 1 mode, 2 operation, 3 software reset |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data, combinational from rd_addr_i and the registers |
| run_o | output | 1 | Data engine may shift |
| pause_o | output | 1 | Data engine holds its position |
| hold_rst_o | output | 1 | Data engine counters and pointers held cleared |

## Verification
A write takes effect at the clock edge that samples it. The read data and all three controls show the new state and the cleared settle flag at the following falling edge, where the bench samples them. The settle flag then reads 0 at exactly SETTLE_CYC falling edges and 1 at the next one. The directed checks count falling edges from the write to confirm this. A reference model in the bench, stepped once per rising edge, predicts every register and output for the constrained-random phase. The bench compares them each cycle after the edge.

// File: rtl/sereng_pkg.sv
package sereng_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_CLEAR  = 2'd2,
    ST_FROZEN = 2'd3
  } st_code_e;

  localparam logic [ADDR_W-1:0] A_STATE = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 2'd1;
  localparam logic [ADDR_W-1:0] A_OPER  = 2'd2;
  localparam logic [ADDR_W-1:0] A_SWRST = 2'd3;
endpackage

// File: rtl/sereng_settle_timer.sv
module sereng_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic valid_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_V;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign valid_o = (cnt_q == '0);
endmodule

// File: rtl/sereng_state_fsm.sv
module sereng_state_fsm
  import sereng_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       swrst_i,
  input  logic       st_wr_i,
  input  logic [1:0] code_i,
  output st_code_e   state_o,
  output logic       settle_o
);
  st_code_e st_q, st_d;
  logic     pend_q, pend_d;
  st_code_e req;

  assign req = st_code_e'(code_i);

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    settle_o = 1'b0;
    if (swrst_i) begin
      st_d     = ST_IDLE;
      pend_d   = 1'b0;
      settle_o = 1'b1;
    end else if (st_wr_i) begin
      if (st_q == ST_FROZEN && pend_q) begin
        // second write decides: clear completes the exit, anything else disarms
        pend_d = 1'b0;
        if (req == ST_CLEAR) begin
          st_d     = ST_IDLE;
          settle_o = 1'b1;
        end
      end else if (req == ST_CLEAR) begin
        if (st_q == ST_FROZEN) pend_d = 1'b1;
      end else begin
        st_d     = req;
        settle_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/sereng_cfg_regs.sv
module sereng_cfg_regs #(
  parameter int REG_N = 2,
  parameter int CFG_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic [REG_N-1:0]         wr_sel_i,
  input  logic [CFG_W-1:0]         wr_data_i,
  output logic [REG_N-1:0][CFG_W-1:0] val_o
);
  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic [CFG_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          r_q <= '0;
      else if (clr_i)       r_q <= '0;
      else if (wr_sel_i[g]) r_q <= wr_data_i;
    end
    assign val_o[g] = r_q;
  end
endmodule

// File: rtl/sereng_state_ctrl.sv
module sereng_state_ctrl
  import sereng_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CFG_W      = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              run_o,
  output logic              pause_o,
  output logic              hold_rst_o
);
  localparam int REG_N = 2;

  logic     valid;
  logic     swrst_hit, st_wr_ok, settle_start;
  st_code_e state;
  logic [REG_N-1:0]            cfg_sel;
  logic [REG_N-1:0][CFG_W-1:0] cfg_val;

  assign swrst_hit = wr_en_i && (wr_addr_i == A_SWRST) && wr_data_i[0];
  assign st_wr_ok  = wr_en_i && (wr_addr_i == A_STATE) && valid;
  assign cfg_sel   = {wr_en_i && (wr_addr_i == A_OPER),
                      wr_en_i && (wr_addr_i == A_MODE)};

  sereng_state_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .swrst_i  (swrst_hit),
    .st_wr_i  (st_wr_ok),
    .code_i   (wr_data_i[1:0]),
    .state_o  (state),
    .settle_o (settle_start)
  );

  sereng_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (settle_start),
    .valid_o (valid)
  );

  sereng_cfg_regs #(.REG_N(REG_N), .CFG_W(CFG_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (swrst_hit),
    .wr_sel_i  (cfg_sel),
    .wr_data_i (wr_data_i[CFG_W-1:0]),
    .val_o     (cfg_val)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_STATE: rd_data_o[2:0] = {valid, state};
      A_MODE:  rd_data_o[CFG_W-1:0] = cfg_val[0];
      A_OPER:  rd_data_o[CFG_W-1:0] = cfg_val[1];
      default: rd_data_o = '0;
    endcase
  end

  assign run_o      = (state == ST_RUN);
  assign pause_o    = (state == ST_FROZEN);
  assign hold_rst_o = (state == ST_IDLE);
endmodule

// File: rtl/sereng_state_chk.sv
module sereng_state_chk #(
  parameter int DATA_W     = 32,
  parameter int SETTLE_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              run_o,
  input logic              pause_o,
  input logic              hold_rst_o,
  input logic              valid_i
);
  logic sw_hit, st_wr;
  int   low_cnt;

  assign sw_hit = wr_en_i && (wr_addr_i == 2'd3) && wr_data_i[0];
  assign st_wr  = wr_en_i && (wr_addr_i == 2'd0) && !sw_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt <= 0;
    else if (sw_hit)  low_cnt <= 0;
    else if (!valid_i) low_cnt <= low_cnt + 1;
    else              low_cnt <= 0;
  end

  // R2
  one_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({run_o, pause_o, hold_rst_o}) == 1);

  // R3
  settle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr && valid_i && !pause_o && (wr_data_i[1:0] != 2'd2) |=> !valid_i);

  // R3
  settle_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> low_cnt < SETTLE_CYC);

  // R4
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr && !valid_i |=> $stable({run_o, pause_o, hold_rst_o}));

  // R7
  clear_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr && valid_i && !pause_o && (wr_data_i[1:0] == 2'd2)
      |=> valid_i && $stable({run_o, pause_o, hold_rst_o}));

  // R8
  swrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_hit |=> hold_rst_o && !valid_i);
endmodule

bind sereng_state_ctrl sereng_state_chk #(.DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .run_o      (run_o),
  .pause_o    (pause_o),
  .hold_rst_o (hold_rst_o),
  .valid_i    (valid)
);

// File: tb/tb_sereng_state_ctrl.sv
module tb_sereng_state_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int CFG_W      = 16;
  localparam int SETTLE     = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [1:0]        wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [1:0]        rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              run_o, pause_o, hold_rst_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  int          m_st = 0;
  bit          m_pend = 1'b0;
  int          m_cnt = 0;
  logic [CFG_W-1:0] m_mode = '0, m_oper = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sereng_state_ctrl #(.DATA_W(DATA_W), .CFG_W(CFG_W), .SETTLE_CYC(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .run_o(run_o), .pause_o(pause_o), .hold_rst_o(hold_rst_o)
  );

  function automatic logic [DATA_W-1:0] exp_rd(input logic [1:0] a);
    logic [DATA_W-1:0] r;
    r = '0;
    case (a)
      2'd0: r[2:0] = {(m_cnt == 0), 2'(m_st)};
      2'd1: r[CFG_W-1:0] = m_mode;
      2'd2: r[CFG_W-1:0] = m_oper;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model(input logic we, input logic [1:0] a, input logic [DATA_W-1:0] d);
    bit was_valid;
    was_valid = (m_cnt == 0);
    if (m_cnt != 0) m_cnt--;
    if (!we) return;
    if (a == 2'd3) begin
      if (d[0]) begin
        m_st = 0; m_pend = 0; m_mode = '0; m_oper = '0; m_cnt = SETTLE;
      end
    end else if (a == 2'd1) m_mode = d[CFG_W-1:0];
    else if (a == 2'd2) m_oper = d[CFG_W-1:0];
    else if (was_valid) begin
      if (m_st == 3 && m_pend) begin
        m_pend = 0;
        if (d[1:0] == 2'd2) begin m_st = 0; m_cnt = SETTLE; end
      end else if (d[1:0] == 2'd2) begin
        if (m_st == 3) m_pend = 1;
      end else begin
        m_st = int'(d[1:0]); m_cnt = SETTLE;
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk(rd_data_o == exp_rd(rd_addr_i), tag, rd_data_o, exp_rd(rd_addr_i));
    chk({run_o, pause_o, hold_rst_o} == {m_st == 1, m_st == 3, m_st == 0}, tag,
        DATA_W'({run_o, pause_o, hold_rst_o}),
        DATA_W'({m_st == 1, m_st == 3, m_st == 0}));
  endtask

  // drive at falling edge, model at rising edge, sample at next falling edge
  task automatic step(input logic we, input logic [1:0] a, input logic [DATA_W-1:0] d,
                      input logic [1:0] ra);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; rd_addr_i = ra;
    @(posedge clk);
    model(we, a, d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic st_wr(input logic [1:0] code);
    step(1'b1, 2'd0, {30'h3ABCDEF0, code}, 2'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, 2'd0);
  endtask

  task automatic exp_state(input logic [2:0] v, input string tag);
    chk(rd_addr_i == 2'd0 && rd_data_o == DATA_W'(v), tag, rd_data_o, DATA_W'(v));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    rd_addr_i = 2'd0; #1;
    exp_state(3'b100, "R1");
    chk(hold_rst_o && !run_o && !pause_o, "R1", DATA_W'({run_o, pause_o, hold_rst_o}), 1);
    rd_addr_i = 2'd1; #1; chk(rd_data_o == 0, "R1", rd_data_o, 0);
    rd_addr_i = 2'd2; #1; chk(rd_data_o == 0, "R1", rd_data_o, 0);

    // R2 / R3: enter running, settle window length
    st_wr(2'd1);
    chk(run_o && !hold_rst_o, "R2", DATA_W'({run_o, pause_o, hold_rst_o}), 3'b100);
    exp_state(3'b001, "R3");
    // R4: write while settling is dropped
    st_wr(2'd3);
    exp_state(3'b001, "R4");
    chk(!pause_o, "R4", DATA_W'(pause_o), 0);
    idle(2);
    exp_state(3'b001, "R3");
    idle(1);
    exp_state(3'b101, "R3");

    // R2: frozen
    st_wr(2'd3); idle(SETTLE);
    exp_state(3'b111, "R2");
    chk(pause_o, "R2", DATA_W'(pause_o), 1);

    // R5: single clear holds, second clear exits
    st_wr(2'd2);
    exp_state(3'b111, "R5");
    st_wr(2'd2);
    exp_state(3'b000, "R5");
    chk(hold_rst_o, "R5", DATA_W'(hold_rst_o), 1);
    idle(SETTLE);

    // R6: pending clear cancelled by another code
    st_wr(2'd1); idle(SETTLE);
    st_wr(2'd3); idle(SETTLE);
    st_wr(2'd2);
    st_wr(2'd1);
    exp_state(3'b111, "R6");
    st_wr(2'd2);
    exp_state(3'b111, "R6");
    st_wr(2'd2);
    exp_state(3'b000, "R6");
    idle(SETTLE);

    // R7: clear outside frozen
    st_wr(2'd2);
    exp_state(3'b100, "R7");
    st_wr(2'd1); idle(SETTLE);
    st_wr(2'd2);
    exp_state(3'b101, "R7");

    // R9: config registers, also while settling
    st_wr(2'd0);
    step(1'b1, 2'd1, 32'hFFFF_A5C3, 2'd1);
    chk(rd_data_o == 32'h0000_A5C3, "R9", rd_data_o, 32'h0000_A5C3);
    step(1'b1, 2'd2, 32'h1234_5678, 2'd2);
    chk(rd_data_o == 32'h0000_5678, "R9", rd_data_o, 32'h0000_5678);
    idle(SETTLE);

    // R8: bit0 clear is no-op, bit0 set resets during settle
    st_wr(2'd1);
    step(1'b1, 2'd3, 32'hFFFF_FFFE, 2'd3);
    chk(rd_data_o == 0, "R8", rd_data_o, 0);
    chk(run_o, "R8", DATA_W'(run_o), 1);
    step(1'b1, 2'd3, 32'h1, 2'd0);
    exp_state(3'b000, "R8");
    rd_addr_i = 2'd1; #1; chk(rd_data_o == 0, "R8", rd_data_o, 0);
    rd_addr_i = 2'd2; #1; chk(rd_data_o == 0, "R8", rd_data_o, 0);
    rd_addr_i = 2'd0;
    idle(SETTLE - 1);
    exp_state(3'b000, "R8");
    idle(1);
    exp_state(3'b100, "R8");

    // constrained random against the model (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic [DATA_W-1:0] d;
      logic we;
      we = ($urandom % 4) != 0;
      a  = ($urandom % 10 == 0) ? 2'd3 : 2'(($urandom % 3 == 0) ? ($urandom % 3) : 0);
      d  = $urandom;
      if (a == 2'd3 && ($urandom % 3) != 0) d[0] = 1'b0;
      step(we, a, d, 2'($urandom % 4));
      cmp_all("RND");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule